// File: doc/BRIEF.md
# Bus Cycle Acknowledge Terminator

This block produces the data-transfer acknowledge that ends every processor bus cycle. It looks at the region that the address decoder has already selected and chooses how the cycle ends. Cycles to on-board memory and to expansion space are acknowledged at once, with no wait states. Cycles to the peripheral region, and interrupt-acknowledge cycles, wait until the addressed peripheral pulls its own acknowledge line low.

The acknowledge pin behaves like an open-collector output, so the block gives two signals: a level and an output enable. A pad cell drives the level only while the enable is high. Otherwise the pin floats and an external pull-up brings it high.

Peripherals that are slow to release the data bus get extra time. A register remembers that a peripheral cycle was acknowledged. After the address strobe rises, the block keeps driving the acknowledge as long as the peripheral keeps its own acknowledge low. This stops the processor from starting the next cycle while the peripheral is still driving the bus.

Top module: `dtack_term_ctrl`

## Requirements
- R1: With the strobe `as_n` low, `iack` low, `io_sel` low and at least one bit of `mem_sel` asserted, `dtack_n` is 0 and `dtack_oe` is 1 in the same cycle. Select bits are active high by default.
- R2: With the strobe low, `iack` low and no bit of `mem_sel` or `io_sel` asserted (expansion space), `dtack_n` is 0 and `dtack_oe` is 1 in the same cycle.
- R3: With the strobe low and `io_sel` high, the output stays released (`dtack_n` 1, `dtack_oe` 0) while `dev_ack_n` is 1. It is driven low in the same cycle that `dev_ack_n` is 0.
- R4: With the strobe low and `iack` high, the cycle waits on `dev_ack_n` exactly as in R3. This holds even when a `mem_sel` bit is asserted at the same time.
- R5: A peripheral or interrupt-acknowledge cycle is acknowledged when a clock edge sees the strobe low and `dev_ack_n` low. After the strobe rises, `dtack_n` stays 0 while `dev_ack_n` stays 0.
- R6: While the strobe is high, the held acknowledge ends at the first rising clock edge that samples `dev_ack_n` as 1. From that edge on, `dtack_n` is 1 and `dtack_oe` is 0.
- R7: The output is open-collector. `dtack_oe` is 1 exactly when `dtack_n` is 0, and `dtack_n` reads 1 whenever the pin is released.
- R8: During reset, and whenever the strobe is high with no held acknowledge, `dtack_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears the held acknowledge |
| as_n | input | 1 | Processor address strobe, active low |
| mem_sel | input | NUM_MEM_SEL (4) | ROM and RAM lane selects from the decoder |
| io_sel | input | 1 | Peripheral region select |
| iack | input | 1 | High during an interrupt-acknowledge cycle |
| dev_ack_n | input | 1 | Peripheral acknowledge, active low; floats high through a pull-up when idle |
| dtack_n | output | 1 | Acknowledge level presented to the pad |
| dtack_oe | output | 1 | Pad output enable; the pin is high impedance when this is 0 |

## Verification
Most results appear in the same cycle as the stimulus, because there is no register on the path from the selects, the strobe and `dev_ack_n` to the outputs. The held acknowledge is the exception: it depends on the register, which the rising edge updates. Because of this, the release described in R6 shows up one sample after `dev_ack_n` rises, not at once. The bench changes its inputs one time unit after each rising edge and updates its own held-acknowledge model at that edge. It then compares both outputs with the model at every falling edge, so every sample falls half a period after the register has settled.

// File: rtl/dtack_pkg.sv
package dtack_pkg;

   // Ending rule chosen for the current bus cycle
   typedef enum logic [1:0] {
      CYC_IDLE = 2'd0,   // strobe high, no cycle in progress
      CYC_MEM  = 2'd1,   // on-board memory, ends at once
      CYC_EXP  = 2'd2,   // expansion space, ends at once
      CYC_DEV  = 2'd3    // peripheral or interrupt acknowledge, waits on the device
   } cyc_kind_e;

   function automatic logic ends_at_once(cyc_kind_e k);
      return (k == CYC_MEM) || (k == CYC_EXP);
   endfunction

endpackage

// File: rtl/dtack_cycle_classify.sv
module dtack_cycle_classify
   import dtack_pkg::*;
#(
   parameter int NUM_MEM_SEL    = 4,
   parameter bit SEL_ACTIVE_LOW = 1'b0
) (
   input  logic                   as_n,
   input  logic [NUM_MEM_SEL-1:0] mem_sel,
   input  logic                   io_sel,
   input  logic                   iack,
   output cyc_kind_e              kind
);

   logic [NUM_MEM_SEL-1:0] mem_hit_vec;
   logic                   io_hit;
   logic                   mem_any;

   // Pick the select polarity at elaboration time
   generate
      if (SEL_ACTIVE_LOW) begin : g_sel_low
         assign mem_hit_vec = ~mem_sel;
         assign io_hit      = ~io_sel;
      end else begin : g_sel_high
         assign mem_hit_vec = mem_sel;
         assign io_hit      = io_sel;
      end
   endgenerate

   assign mem_any = |mem_hit_vec;

   // Interrupt acknowledge and the peripheral region come first. A memory lane
   // that is asserted at the same time cannot end such a cycle early.
   always_comb begin
      if (as_n)                 kind = CYC_IDLE;
      else if (iack || io_hit)  kind = CYC_DEV;
      else if (mem_any)         kind = CYC_MEM;
      else                      kind = CYC_EXP;
   end

endmodule

// File: rtl/dtack_dev_hold.sv
module dtack_dev_hold #(
   parameter bit RELEASE_ON_CLOCK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic as_n,
   input  logic dev_cycle,
   input  logic dev_ack,
   output logic hold_drive
);

   logic hold_q;
   logic hold_d;

   // Set while a device cycle is being acknowledged; cleared when an edge
   // samples the device acknowledge as inactive.
   assign hold_d = dev_ack && (dev_cycle || hold_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= hold_d;
   end

   generate
      if (RELEASE_ON_CLOCK) begin : g_rel_clocked
         // Release waits for the next edge; no path from dev_ack to the pad
         assign hold_drive = hold_q && as_n;
      end else begin : g_rel_direct
         // Release follows the device line at once
         assign hold_drive = hold_q && as_n && dev_ack;
      end
   endgenerate

endmodule

// File: rtl/dtack_od_stage.sv
module dtack_od_stage (
   input  logic drive_low,
   output logic dtack_n,
   output logic dtack_oe
);

   // Open-collector emulation: enable only while pulling low, level reads
   // as the pulled-up value when released.
   assign dtack_oe = drive_low;
   assign dtack_n  = ~drive_low;

endmodule

// File: rtl/dtack_term_ctrl.sv
module dtack_term_ctrl
   import dtack_pkg::*;
#(
   parameter int NUM_MEM_SEL      = 4,
   parameter bit SEL_ACTIVE_LOW   = 1'b0,
   parameter bit RELEASE_ON_CLOCK = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   as_n,
   input  logic [NUM_MEM_SEL-1:0] mem_sel,
   input  logic                   io_sel,
   input  logic                   iack,
   input  logic                   dev_ack_n,
   output logic                   dtack_n,
   output logic                   dtack_oe
);

   localparam int MAX_MEM_SEL = 16;

   generate
      if (NUM_MEM_SEL < 1 || NUM_MEM_SEL > MAX_MEM_SEL) begin : g_bad_sel_count
         $error("dtack_term_ctrl: NUM_MEM_SEL must lie in 1..16");
      end
   endgenerate

   cyc_kind_e kind;
   logic      dev_ack;
   logic      dev_cycle;
   logic      hold_drive;
   logic      drive_low;

   assign dev_ack   = ~dev_ack_n;
   assign dev_cycle = (kind == CYC_DEV);

   dtack_cycle_classify #(
      .NUM_MEM_SEL    (NUM_MEM_SEL),
      .SEL_ACTIVE_LOW (SEL_ACTIVE_LOW)
   ) i_classify (
      .as_n    (as_n),
      .mem_sel (mem_sel),
      .io_sel  (io_sel),
      .iack    (iack),
      .kind    (kind)
   );

   dtack_dev_hold #(
      .RELEASE_ON_CLOCK (RELEASE_ON_CLOCK)
   ) i_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .as_n       (as_n),
      .dev_cycle  (dev_cycle),
      .dev_ack    (dev_ack),
      .hold_drive (hold_drive)
   );

   // The device path gates only on the device line. Grouping it this way keeps
   // a peripheral cycle from being ended by the memory or expansion terms.
   assign drive_low = ends_at_once(kind)
                    | (dev_cycle & dev_ack)
                    | hold_drive;

   dtack_od_stage i_od (
      .drive_low (drive_low),
      .dtack_n   (dtack_n),
      .dtack_oe  (dtack_oe)
   );

endmodule

// File: rtl/dtack_term_chk.sv
module dtack_term_chk #(
   parameter int NUM_MEM_SEL    = 4,
   parameter bit SEL_ACTIVE_LOW = 1'b0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   as_n,
   input logic [NUM_MEM_SEL-1:0] mem_sel,
   input logic                   io_sel,
   input logic                   iack,
   input logic                   dev_ack_n,
   input logic                   dtack_n,
   input logic                   dtack_oe
);

   logic mem_any;
   logic io_on;
   logic dev_cyc;

   assign mem_any = SEL_ACTIVE_LOW ? ~&mem_sel : |mem_sel;
   assign io_on   = SEL_ACTIVE_LOW ? ~io_sel   : io_sel;
   assign dev_cyc = !as_n && (io_on || iack);

   p_mem_zero_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_n && !iack && !io_on && mem_any) |-> (!dtack_n && dtack_oe));

   p_exp_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_n && !iack && !io_on && !mem_any) |-> (!dtack_n && dtack_oe));

   p_io_waits_dev_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_n && io_on && dev_ack_n) |-> (dtack_n && !dtack_oe));

   p_iack_waits_dev_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_n && iack && dev_ack_n) |-> (dtack_n && !dtack_oe));

   p_hold_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (as_n && !dev_ack_n && $past(rst_n) && $past(dev_cyc && !dev_ack_n))
      |-> !dtack_n);

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (as_n && $past(as_n) && $past(dev_ack_n)) |-> (dtack_n && !dtack_oe));

   p_open_collector_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dtack_oe != dtack_n));

   p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(as_n) && $past(!dev_cyc)) |-> !dtack_oe);

endmodule

bind dtack_term_ctrl dtack_term_chk #(
   .NUM_MEM_SEL    (NUM_MEM_SEL),
   .SEL_ACTIVE_LOW (SEL_ACTIVE_LOW)
) i_dtack_term_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .as_n      (as_n),
   .mem_sel   (mem_sel),
   .io_sel    (io_sel),
   .iack      (iack),
   .dev_ack_n (dev_ack_n),
   .dtack_n   (dtack_n),
   .dtack_oe  (dtack_oe)
);

// File: tb/test_dtack_term_ctrl.sv
module test_dtack_term_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NSEL       = 4;
   localparam int WATCHDOG   = 5000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            as_n = 1'b1;
   logic [NSEL-1:0] mem_sel = '0;
   logic            io_sel = 1'b0;
   logic            iack = 1'b0;
   logic            dev_ack_n = 1'b1;
   logic            dtack_n;
   logic            dtack_oe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // Behavioural model of the held acknowledge
   bit model_hold      = 1'b0;
   bit model_hold_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dtack_term_ctrl #(.NUM_MEM_SEL(NSEL)) i_dtack_term_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .as_n      (as_n),
      .mem_sel   (mem_sel),
      .io_sel    (io_sel),
      .iack      (iack),
      .dev_ack_n (dev_ack_n),
      .dtack_n   (dtack_n),
      .dtack_oe  (dtack_oe)
   );

   // Model update at the edge, from the inputs that the edge samples
   always @(posedge clk) begin
      model_hold_prev = model_hold;
      if (!rst_n) begin
         model_hold = 1'b0;
      end else if (dev_ack_n) begin
         model_hold = 1'b0;            // R6: an edge sees the device released
      end else if (!as_n && (io_sel || iack)) begin
         model_hold = 1'b1;            // R5: device cycle acknowledged
      end
   end

   task automatic check(string req, logic act_n, logic act_oe, logic exp_n, logic exp_oe);
      total++;
      if (act_n !== exp_n || act_oe !== act_oe || act_oe !== exp_oe) begin
         bad++;
         $display("FAIL %s: dtack_n=%b dtack_oe=%b expected dtack_n=%b dtack_oe=%b at %0t",
                  req, act_n, act_oe, exp_n, exp_oe, $time);
      end
   endtask

   // Compare against the model on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         string tag;
         bit    drv;
         if (!rst_n) begin
            tag = "R8"; drv = 1'b0;
         end else if (!as_n) begin
            if (iack) begin
               tag = "R4"; drv = !dev_ack_n;
            end else if (io_sel) begin
               tag = "R3"; drv = !dev_ack_n;
            end else if (|mem_sel) begin
               tag = "R1"; drv = 1'b1;
            end else begin
               tag = "R2"; drv = 1'b1;
            end
         end else if (model_hold) begin
            tag = "R5"; drv = 1'b1;
         end else if (model_hold_prev) begin
            tag = "R6"; drv = 1'b0;
         end else begin
            tag = "R8"; drv = 1'b0;
         end
         check(tag, dtack_n, dtack_oe, !drv, drv);
         // R7: enable and level are always complementary
         total++;
         if (dtack_oe !== !dtack_n) begin
            bad++;
            $display("FAIL R7: dtack_oe=%b dtack_n=%b expected complementary", dtack_oe, dtack_n);
         end
      end
   end

   task automatic step(logic a, logic [NSEL-1:0] m, logic io, logic ia, logic d, int n);
      as_n = a; mem_sel = m; io_sel = io; iack = ia; dev_ack_n = d;
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step(1, 4'b0000, 0, 0, 1, 2);        // R8 idle after reset
      // R1: zero-wait RAM read on one lane, then another lane
      step(0, 4'b0100, 0, 0, 1, 2);
      step(0, 4'b0001, 0, 0, 1, 1);
      step(1, 4'b0000, 0, 0, 1, 2);
      // R2: expansion read
      step(0, 4'b0000, 0, 0, 1, 2);
      step(1, 4'b0000, 0, 0, 1, 2);
      // R3: peripheral read, device answers after three cycles
      step(0, 4'b0000, 1, 0, 1, 3);
      step(0, 4'b0000, 1, 0, 0, 1);
      step(1, 4'b0000, 0, 0, 0, 2);        // R5 hold
      step(1, 4'b0000, 0, 0, 1, 3);        // R6 release
      // R5/R6: peripheral whose acknowledge lingers after the strobe rises
      step(0, 4'b0000, 1, 0, 1, 1);
      step(0, 4'b0000, 1, 0, 0, 2);
      step(1, 4'b0000, 0, 0, 0, 4);
      step(1, 4'b0000, 0, 0, 1, 2);
      // R4: interrupt acknowledge with a memory lane also asserted
      step(0, 4'b1000, 0, 1, 1, 2);
      step(0, 4'b1000, 0, 1, 0, 1);
      step(1, 4'b0000, 0, 0, 0, 1);
      step(1, 4'b0000, 0, 0, 1, 2);
      // R1 straight after a held cycle
      step(0, 4'b0010, 0, 0, 1, 1);
      step(1, 4'b0000, 0, 0, 1, 2);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule